// File: doc/BRIEF.md
# Dual-Bank Colour Matrix

This block transforms a stream of 10-bit RGB pixels through a 3x4 matrix. Each output channel is a signed weighted sum of the three input channels plus a per-row offset, rounded back to integer codes and clamped to the 10-bit range. Two complete coefficient banks are held, so one bank can be rewritten while the other is in use. A two-bit mode selects bypass, bank A or bank B.

The requested mode is an input, but it is only adopted on a frame-start pulse. The adopted mode is driven on a separate output so that the programming side can see which bank is live and rewrite the other one. Pixels enter with a valid strobe and emerge two cycles later with the valid strobe delayed alongside them, in every mode.

Coefficients are written one 32-bit word at a time. Each word carries two 16-bit coefficients, and each bank has six words.

Top module: `dual_bank_remap`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` is 0, `modeCur` is 0 (bypass), the output channels are 0, and every coefficient in both banks is 0.
- R2: A write with `cfgWrEn` high stores `cfgWrData` at word address `cfgAddr`. Bit 3 selects the bank (0 = A, 1 = B). Bits 2:0 select word k, for k from 0 to 5. Word k holds the coefficients at row-major positions 2k (bits 15:0) and 2k+1 (bits 31:16), in the order C11 C12 C13 C14 C21 ... C34. Column 4 of each row is the offset.
- R3: In a matrix mode, each output row n equals clamp(round((Cn1*R + Cn2*G + Cn3*B) / 8192) + Cn4). The multipliers are signed two's-complement values with 13 fractional bits. The offset Cn4 is a signed integer in output codes. Rounding adds one half and then takes the floor. Row 1 drives `outR`, row 2 drives `outG` and row 3 drives `outB`.
- R4: `modeCur` = 1 applies bank A and `modeCur` = 2 applies bank B.
- R5: `modeCur` = 0 passes `pixR`/`pixG`/`pixB` to the outputs unchanged.
- R6: `modeCur` changes only at a clock edge where `frameStart` is high. At that edge it takes `modeReq`, and the reserved code 3 becomes 0. A pixel accepted on that same edge still uses the previous mode.
- R7: Results below 0 give 0, and results above 1023 give 1023.
- R8: A pixel accepted at edge k appears at edge k+2 with `outValid` high. `outValid` is low in every other cycle.
- R9: A coefficient write affects the pixels accepted after the write edge. Writes to the bank that is not in use leave the outputs unchanged.
- R10: Writes with `cfgAddr[2:0]` equal to 6 or 7 change no coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Coefficient word write strobe |
| cfgAddr | input | 4 | Bank bit and word index |
| cfgWrData | input | 32 | Two packed coefficients |
| modeReq | input | 2 | Requested mode: 0 bypass, 1 bank A, 2 bank B |
| frameStart | input | 1 | Frame boundary pulse that adopts modeReq |
| pixValid | input | 1 | Input pixel valid |
| pixR | input | 10 | Input red |
| pixG | input | 10 | Input green |
| pixB | input | 10 | Input blue |
| outValid | output | 1 | Output pixel valid |
| outR | output | 10 | Output red |
| outG | output | 10 | Output green |
| outB | output | 10 | Output blue |
| modeCur | output | 2 | Mode actually applied |

## Verification
A wrong internal state has visible effects at the ports:
- A stale mode register shows up on `modeCur` one cycle after the frame pulse that should have changed it.
- A bank mix-up, a misplaced coefficient half or a mis-decoded word index corrupts the very next valid pixel two cycles after acceptance, because every coefficient feeds some output row.
- A lost or extra pipeline stage flips `outValid` against the expected two-cycle slot.

The reference model checks every cycle, so each of these faults is caught within three cycles of the stimulus that exposes it.

// File: rtl/remap_pkg.sv
package remap_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_SET_A  = 2'd1,
    MODE_SET_B  = 2'd2,
    MODE_RSVD   = 2'd3
  } remapMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic matrixOn;
    logic bankB;
  } remapStrobe_t;

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl #(
  parameter int COEF_W = 16,
  parameter int ROWS   = 3,
  parameter int ADDR_W = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cfgWrEn,
  input  logic [ADDR_W-1:0]                 cfgAddr,
  input  logic [2*COEF_W-1:0]               cfgWrData,
  input  logic [1:0]                        modeReq,
  input  logic                              frameStart,
  output logic [1:0]                        modeCur,
  output remap_pkg::remapStrobe_t           strobe,
  output logic [ROWS*(ROWS+1)-1:0][COEF_W-1:0] coefSel
);
  import remap_pkg::*;

  localparam int N_COEF  = ROWS * (ROWS + 1);
  localparam int N_WORDS = N_COEF / 2;
  localparam int IDX_W   = ADDR_W - 1;

  logic [1:0][N_WORDS-1:0][2*COEF_W-1:0] bankRegs;
  remapMode_e modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankRegs <= '0;
    end else if (cfgWrEn) begin
      for (int b = 0; b < 2; b++) begin
        for (int w = 0; w < N_WORDS; w++) begin
          if (cfgAddr[ADDR_W-1] == 1'(b) && cfgAddr[IDX_W-1:0] == IDX_W'(w))
            bankRegs[b][w] <= cfgWrData;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_BYPASS;
    end else if (frameStart) begin
      modeQ <= (remapMode_e'(modeReq) == MODE_RSVD) ? MODE_BYPASS : remapMode_e'(modeReq);
    end
  end

  assign modeCur         = modeQ;
  assign strobe.matrixOn = (modeQ == MODE_SET_A) || (modeQ == MODE_SET_B);
  assign strobe.bankB    = (modeQ == MODE_SET_B);

  for (genvar w = 0; w < N_WORDS; w++) begin : g_unpack
    assign coefSel[2*w]   = bankRegs[strobe.bankB][w][COEF_W-1:0];
    assign coefSel[2*w+1] = bankRegs[strobe.bankB][w][2*COEF_W-1:COEF_W];
  end

endmodule

// File: rtl/remap_datapath.sv
module remap_datapath #(
  parameter int COEF_W = 16,
  parameter int FRAC_W = 13,
  parameter int PIX_W  = 10,
  parameter int ROWS   = 3
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  remap_pkg::remapStrobe_t              strobe,
  input  logic [ROWS*(ROWS+1)-1:0][COEF_W-1:0] coefSel,
  input  logic                                 pixValid,
  input  logic [ROWS-1:0][PIX_W-1:0]           pixIn,
  output logic                                 outValid,
  output logic [ROWS-1:0][PIX_W-1:0]           pixOut
);
  localparam int ACC_W = COEF_W + FRAC_W + 2;
  localparam int COLS  = ROWS + 1;
  localparam logic signed [ACC_W-1:0] ROUND = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] MAXV  = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] sumC [ROWS];
  logic signed [ACC_W-1:0] accQ [ROWS];
  logic signed [ACC_W-1:0] rndC [ROWS];
  logic [ROWS-1:0][PIX_W-1:0] pixQ;
  logic [ROWS-1:0][PIX_W-1:0] resC;
  logic matrixQ;
  logic validQ;

  // Stage 1 combinational: multiply-accumulate per row
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      sumC[r] = ACC_W'($signed(coefSel[r*COLS+ROWS])) <<< FRAC_W;
      for (int c = 0; c < ROWS; c++) begin
        sumC[r] = sumC[r] + ACC_W'($signed(coefSel[r*COLS+c])) *
                            ACC_W'($signed({1'b0, pixIn[c]}));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      matrixQ <= 1'b0;
      pixQ    <= '0;
      for (int r = 0; r < ROWS; r++) accQ[r] <= '0;
    end else begin
      validQ  <= pixValid;
      matrixQ <= strobe.matrixOn;
      pixQ    <= pixIn;
      for (int r = 0; r < ROWS; r++) accQ[r] <= sumC[r];
    end
  end

  // Stage 2 combinational: round, clamp, bypass select
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      rndC[r] = (accQ[r] + ROUND) >>> FRAC_W;
      if (!matrixQ)          resC[r] = pixQ[r];
      else if (rndC[r] < 0)  resC[r] = '0;
      else if (rndC[r] > MAXV) resC[r] = MAXV[PIX_W-1:0];
      else                   resC[r] = rndC[r][PIX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      pixOut   <= '0;
    end else begin
      outValid <= validQ;
      pixOut   <= resC;
    end
  end

endmodule

// File: rtl/dual_bank_remap.sv
module dual_bank_remap #(
  parameter int COEF_W = 16,
  parameter int FRAC_W = 13,
  parameter int PIX_W  = 10,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [2*COEF_W-1:0] cfgWrData,
  input  logic [1:0]          modeReq,
  input  logic                frameStart,
  input  logic                pixValid,
  input  logic [PIX_W-1:0]    pixR,
  input  logic [PIX_W-1:0]    pixG,
  input  logic [PIX_W-1:0]    pixB,
  output logic                outValid,
  output logic [PIX_W-1:0]    outR,
  output logic [PIX_W-1:0]    outG,
  output logic [PIX_W-1:0]    outB,
  output logic [1:0]          modeCur
);
  localparam int ROWS = 3;

  remap_pkg::remapStrobe_t strobe;
  logic [ROWS*(ROWS+1)-1:0][COEF_W-1:0] coefSel;
  logic [ROWS-1:0][PIX_W-1:0] pixIn;
  logic [ROWS-1:0][PIX_W-1:0] pixOut;

  assign pixIn = {pixB, pixG, pixR};
  assign outR  = pixOut[0];
  assign outG  = pixOut[1];
  assign outB  = pixOut[2];

  remap_ctrl #(.COEF_W(COEF_W), .ROWS(ROWS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .modeReq(modeReq), .frameStart(frameStart),
    .modeCur(modeCur), .strobe(strobe), .coefSel(coefSel)
  );

  remap_datapath #(.COEF_W(COEF_W), .FRAC_W(FRAC_W), .PIX_W(PIX_W), .ROWS(ROWS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .coefSel(coefSel),
    .pixValid(pixValid), .pixIn(pixIn), .outValid(outValid), .pixOut(pixOut)
  );

endmodule

// File: rtl/remap_checker.sv
module remap_checker #(
  parameter int PIX_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeReq,
  input logic             frameStart,
  input logic             pixValid,
  input logic [PIX_W-1:0] pixR,
  input logic             outValid,
  input logic [PIX_W-1:0] outR,
  input logic [1:0]       modeCur
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (!rstN) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (age != 2'd0 && !$past(frameStart)) |-> $stable(modeCur)); // R6

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (age != 2'd0 && $past(frameStart)) |->
      modeCur == (($past(modeReq) == 2'd3) ? 2'd0 : $past(modeReq))); // R6

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    modeCur != 2'd3); // R6

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |-> outValid == $past(pixValid, 2)); // R8

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && $past(pixValid, 2) && $past(modeCur, 2) == 2'd0)
      |-> outR == $past(pixR, 2)); // R5

endmodule

bind dual_bank_remap remap_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeReq(modeReq), .frameStart(frameStart),
  .pixValid(pixValid), .pixR(pixR), .outValid(outValid), .outR(outR),
  .modeCur(modeCur)
);

// File: tb/sim_dual_bank_remap.sv
`timescale 1ns/100ps
module sim_dual_bank_remap;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [1:0] modeReq = '0;
  logic frameStart = 1'b0;
  logic pixValid = 1'b0;
  logic [9:0] pixR = '0, pixG = '0, pixB = '0;
  logic outValid;
  logic [9:0] outR, outG, outB;
  logic [1:0] modeCur;

  always #2.5 clk = ~clk;

  dual_bank_remap u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .modeReq(modeReq), .frameStart(frameStart),
    .pixValid(pixValid), .pixR(pixR), .pixG(pixG), .pixB(pixB),
    .outValid(outValid), .outR(outR), .outG(outG), .outB(outB),
    .modeCur(modeCur)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference state
  int coef [2][12];
  int mMode = 0;
  // Expected pipeline: [0] = stage 1, [1] = output
  bit eValid [2];
  int eR [2], eG [2], eB [2];
  string eTag [2];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clampRow(input int row, input int r, input int g, input int b,
                                  input int bank, inout bit sat);
    int acc, v;
    acc = coef[bank][row*4]*r + coef[bank][row*4+1]*g + coef[bank][row*4+2]*b;
    v = ((acc + 4096) >>> 13) + coef[bank][row*4+3];
    if (v < 0) begin sat = 1; return 0; end
    if (v > 1023) begin sat = 1; return 1023; end
    return v;
  endfunction

  // One clock: inputs already applied; model this edge, then check after it
  task automatic step(input bit v, input int r, input int g, input int b,
                      input bit fs, input int mr, input bit we, input int a, input int d);
    bit sat;
    int nr, ng, nb;
    string tag;
    pixValid = v; pixR = 10'(r); pixG = 10'(g); pixB = 10'(b);
    frameStart = fs; modeReq = 2'(mr);
    cfgWrEn = we; cfgAddr = 4'(a); cfgWrData = 32'(d);
    sat = 0;
    if (mMode == 0) begin nr = r; ng = g; nb = b; tag = "R5"; end
    else begin
      nr = clampRow(0, r, g, b, mMode - 1, sat);
      ng = clampRow(1, r, g, b, mMode - 1, sat);
      nb = clampRow(2, r, g, b, mMode - 1, sat);
      tag = sat ? "R7" : (mMode == 1 ? "R3/R4 bankA" : "R3/R4 bankB");
    end
    @(posedge clk);
    eValid[1] = eValid[0]; eR[1] = eR[0]; eG[1] = eG[0]; eB[1] = eB[0]; eTag[1] = eTag[0];
    eValid[0] = v; eR[0] = nr; eG[0] = ng; eB[0] = nb; eTag[0] = tag;
    if (we && (a & 7) < 6) begin   // R2 / R10: words 6 and 7 ignored
      coef[(a >> 3) & 1][2*(a & 7)]   = int'($signed(d[15:0]));
      coef[(a >> 3) & 1][2*(a & 7)+1] = int'($signed(d[31:16]));
    end
    if (fs) mMode = (mr == 3) ? 0 : mr;
    @(negedge clk);
    check(outValid == eValid[1], "R8 valid", outValid, eValid[1]);
    check(modeCur == 2'(mMode), "R6 modeCur", modeCur, mMode);
    if (eValid[1]) begin
      check(outR == 10'(eR[1]), {eTag[1], " R"}, outR, eR[1]);
      check(outG == 10'(eG[1]), {eTag[1], " G"}, outG, eG[1]);
      check(outB == 10'(eB[1]), {eTag[1], " B"}, outB, eB[1]);
    end
  endtask

  task automatic pix(input int n, input bit gaps);
    for (int i = 0; i < n; i++)
      step(gaps ? ($urandom % 3 != 0) : 1'b1, $urandom % 1024, $urandom % 1024,
           $urandom % 1024, 0, mMode, 0, 0, 0);
  endtask

  task automatic wr(input int a, input int d);
    step(1, $urandom % 1024, $urandom % 1024, $urandom % 1024, 0, mMode, 1, a, d);
  endtask

  task automatic frame(input int mr);
    step(1, $urandom % 1024, $urandom % 1024, $urandom % 1024, 1, mr, 0, 0, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int k = 0; k < 12; k++) coef[b][k] = 0;
    for (int s = 0; s < 2; s++) begin eValid[s] = 0; eR[s] = 0; eG[s] = 0; eB[s] = 0; eTag[s] = ""; end
    repeat (4) @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1 valid", outValid, 0);
    check(modeCur == 2'd0, "R1 mode", modeCur, 0);
    check({outR, outG, outB} == '0, "R1 data", outR, 0);
    rstN = 1'b1;
    // R1: banks zero - enter bank A with nothing written, matrix gives 0
    pix(40, 1);                            // R5, R8 bypass with gaps
    frame(1);                              // R6 boundary pixel uses bypass
    pix(6, 0);                             // R1: all-zero bank A
    // Bank A: identity with offsets +5 / -3 / 0
    wr(0, 32'h0000_2000);
    wr(1, 32'h0005_0000);
    wr(2, 32'h2000_0000);
    wr(3, 32'hFFFD_0000);
    wr(4, 32'h0000_0000);
    wr(5, 32'h0000_2000);
    pix(30, 1);                            // R3, R4, R7 at edges
    step(1, 1023, 0, 2, 0, 1, 0, 0, 0);    // R7 clamp high and low
    // R9: random bank B while A is live
    for (int w = 0; w < 6; w++) wr(8 + w, $urandom);
    pix(10, 0);
    // R10: words 6 and 7 of both banks ignored
    wr(6, 32'h7FFF_7FFF);
    wr(7, 32'h8000_8000);
    wr(14, 32'h7FFF_7FFF);
    wr(15, 32'h1234_5678);
    pix(10, 0);
    // R6: request without frame pulse has no effect
    step(1, 100, 200, 300, 0, 2, 0, 0, 0);
    pix(4, 0);
    frame(2);                              // R4 bank B
    pix(30, 1);
    // R7 explicit on bank B: huge positive red offset, huge negative green offset
    wr(9, 32'h7FFF_1000);
    wr(11, 32'h8000_0800);
    pix(10, 0);
    // R3 signed fractional multipliers on bank A (inactive, then switch)
    wr(0, 32'hF000_3000);                  // C11=1.5, C12=-0.5
    wr(1, 32'h0000_0800);                  // C13=0.25, C14=0
    frame(1);
    pix(20, 0);
    step(1, 3, 0, 0, 0, 1, 0, 0, 0);       // rounding: 4.5 -> 5
    frame(3);                              // R6 reserved code -> bypass
    pix(20, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule